// File: doc/BRIEF.md
# Dual-Bank Operand Register File

This block is the operand store for a three-operand arithmetic unit. It has twenty general 64-bit registers, ten in bank A and ten in bank B, and two feedback registers, C and CT, that hold temporary values. It offers two combinational read ports and one write port. Every instruction presents three select fields and an operation class. The block checks that the selected operands obey the bank rules for that class. An illegal combination raises a flag in the same cycle and the write is blocked.

A merge mode bit lifts the bank rules. In merge mode, register n of bank A and register n of bank B name the same storage, so either read port can reach any of the ten shared registers. When merge mode is entered, the shared contents are those of bank A. A write made in merge mode lands in both banks, so the value is still seen after merge mode is left. A read of the location being written in the same cycle returns the new data.

The ports are plain, level-sampled control and data pins. Nothing in this block applies back-pressure: one instruction is accepted on every clock, and there is no valid/ready pair.

Top module: `opnd_regfile`

## Requirements
- R1: After reset, every general and feedback register reads zero and the sticky error output is low.
- R2: A legal write (write enable high, illegal flag low) stores the write data on the rising clock edge. Reads are combinational from the stored state.
- R3: Outside merge mode, with class 0 (dual-source), the first source must be a bank-A register and the second source must be a bank-B register. Otherwise the illegal flag is high.
- R4: Outside merge mode, class 1 (square) requires a bank-A first source, and class 2 (reciprocal) requires a bank-B first source. Class 3 (move) accepts a first source from either bank.
- R5: The destination may name a register in either bank. The bank of the destination never makes an instruction illegal.
- R6: A select field is 5 bits. Bit 4 is the bank (0 = A, 1 = B). Bits 3:0 equal to 0-9 pick a general register, 10 picks C and 11 picks CT, whatever the bank bit is. Codes 12-15 are illegal on any port that is in use. Feedback registers satisfy every bank rule.
- R7: In merge mode, the bank rules are lifted. Register n in bank A and register n in bank B read the same value, taken from bank A. A write through either name updates both banks.
- R8: When a legal write targets the location that a read port selects, that read port returns the write data in the same cycle.
- R9: An illegal instruction does not change any register. The sticky error output goes high on the next clock edge and stays high until reset.
- R10: The second select field is used only by class 0. For classes 1-3 its code is not checked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| merge_mode | input | 1 | Merge banks A and B |
| op_class | input | 2 | 0 dual-source, 1 square, 2 reciprocal, 3 move |
| src1_sel | input | 5 | First source select |
| src2_sel | input | 5 | Second source select |
| dst_sel | input | 5 | Destination select |
| wr_en | input | 1 | Write request for this instruction |
| wr_data | input | 64 | Write data |
| rd1_data | output | 64 | First source data |
| rd2_data | output | 64 | Second source data |
| illegal | output | 1 | Current instruction breaks a rule |
| err_flag | output | 1 | Sticky error |

## Verification
The bench drives swapped banks for each class, and a feedback register selected with the bank bit set. A design that applies bank rules to feedback registers, or that swaps the square and reciprocal rules, flags legal instructions or accepts illegal ones. An illegal write is followed by a read of its target. A design that commits the write anyway shows the new data there. The bench writes through a bank-B name in merge mode and then reads both names after leaving merge mode. A design that keeps the banks separate while merged returns stale data for the A name. Same-cycle reads of the write target, including across bank names while merged, expose a missing or over-eager bypass. An illegal code on the unused second port shows whether that port is wrongly checked.

// File: rtl/opf_pkg.sv
package opf_pkg;
  typedef enum logic [1:0] {
    OPC_DUAL   = 2'd0,
    OPC_SQUARE = 2'd1,
    OPC_RECIP  = 2'd2,
    OPC_MOVE   = 2'd3
  } opc_e;

  // Bank demanded of the first source: need flag and bank value.
  function automatic logic [1:0] src1_rule(input opc_e op);
    case (op)
      OPC_DUAL:   src1_rule = 2'b10;
      OPC_SQUARE: src1_rule = 2'b10;
      OPC_RECIP:  src1_rule = 2'b11;
      default:    src1_rule = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/opf_sel_decode.sv
module opf_sel_decode #(
  parameter int NUM_GEN = 10,
  parameter int IDX_W   = 4
) (
  input  logic [IDX_W:0]   sel,
  output logic             ok,
  output logic             fb,
  output logic             fb_ct,
  output logic             bank,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] C_CODE  = IDX_W'(NUM_GEN);
  localparam logic [IDX_W-1:0] CT_CODE = IDX_W'(NUM_GEN + 1);

  always_comb begin
    idx   = sel[IDX_W-1:0];
    bank  = sel[IDX_W];
    fb    = (idx == C_CODE) || (idx == CT_CODE);
    fb_ct = (idx == CT_CODE);
    ok    = (idx < C_CODE) || fb;
  end
endmodule

// File: rtl/opf_rule_check.sv
module opf_rule_check
  import opf_pkg::*;
(
  input  logic       merge_mode,
  input  opc_e       op,
  input  logic       wr_en,
  input  logic [2:0] sel_ok,
  input  logic [2:0] sel_fb,
  input  logic [2:0] sel_bank,
  output logic       illegal
);
  logic [1:0] rule1;
  logic       bad1, bad2, badd, s2_used;

  always_comb begin
    rule1   = src1_rule(op);
    s2_used = (op == OPC_DUAL);
    bad1 = !sel_ok[0] ||
           (!merge_mode && !sel_fb[0] && rule1[1] && (sel_bank[0] != rule1[0]));
    bad2 = !sel_ok[1] ||
           (!merge_mode && !sel_fb[1] && (sel_bank[1] != 1'b1));
    badd = wr_en && !sel_ok[2];
    illegal = bad1 || (s2_used && bad2) || badd;
  end
endmodule

// File: rtl/opf_storage.sv
module opf_storage #(
  parameter int DW      = 64,
  parameter int NUM_GEN = 10,
  parameter int IDX_W   = 4,
  parameter int NRD     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                merge_mode,
  input  logic                we,
  input  logic                w_fb,
  input  logic                w_ct,
  input  logic                w_bank,
  input  logic [IDX_W-1:0]    w_idx,
  input  logic [DW-1:0]       w_data,
  input  logic [NRD-1:0]      r_ok,
  input  logic [NRD-1:0]      r_fb,
  input  logic [NRD-1:0]      r_ct,
  input  logic [NRD-1:0]      r_bank,
  input  logic [IDX_W-1:0]    r_idx  [NRD],
  output logic [DW-1:0]       r_data [NRD]
);
  logic [DW-1:0] bank_a [NUM_GEN];
  logic [DW-1:0] bank_b [NUM_GEN];
  logic [DW-1:0] fb_c, fb_ct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_GEN; i++) begin
        bank_a[i] <= '0;
        bank_b[i] <= '0;
      end
      fb_c  <= '0;
      fb_ct <= '0;
    end else if (we) begin
      if (w_fb) begin
        if (w_ct) fb_ct <= w_data;
        else      fb_c  <= w_data;
      end else begin
        for (int i = 0; i < NUM_GEN; i++) begin
          if (w_idx == IDX_W'(i)) begin
            if (merge_mode || !w_bank) bank_a[i] <= w_data;
            if (merge_mode ||  w_bank) bank_b[i] <= w_data;
          end
        end
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic          hit;
    logic [DW-1:0] stored;
    always_comb begin
      stored = '0;
      if (r_fb[p]) begin
        stored = r_ct[p] ? fb_ct : fb_c;
      end else begin
        for (int i = 0; i < NUM_GEN; i++) begin
          if (r_idx[p] == IDX_W'(i))
            stored = (merge_mode || !r_bank[p]) ? bank_a[i] : bank_b[i];
        end
      end
      if (r_fb[p] || w_fb)
        hit = r_fb[p] && w_fb && (r_ct[p] == w_ct);
      else
        hit = (r_idx[p] == w_idx) && (merge_mode || (r_bank[p] == w_bank));
      if (!r_ok[p])        r_data[p] = '0;
      else if (we && hit)  r_data[p] = w_data;
      else                 r_data[p] = stored;
    end
  end
endmodule

// File: rtl/opnd_regfile.sv
module opnd_regfile
  import opf_pkg::*;
#(
  parameter int DW      = 64,
  parameter int NUM_GEN = 10,
  parameter int IDX_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            merge_mode,
  input  logic [1:0]      op_class,
  input  logic [IDX_W:0]  src1_sel,
  input  logic [IDX_W:0]  src2_sel,
  input  logic [IDX_W:0]  dst_sel,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd1_data,
  output logic [DW-1:0]   rd2_data,
  output logic            illegal,
  output logic            err_flag
);
  localparam int NSEL = 3;

  logic [IDX_W:0]   sel_in [NSEL];
  logic [NSEL-1:0]  s_ok, s_fb, s_ct, s_bank;
  logic [IDX_W-1:0] s_idx [NSEL];
  logic [IDX_W-1:0] r_idx [2];
  logic [DW-1:0]    r_data [2];
  logic             wr_ok;

  assign sel_in[0] = src1_sel;
  assign sel_in[1] = src2_sel;
  assign sel_in[2] = dst_sel;

  for (genvar k = 0; k < NSEL; k++) begin : g_dec
    opf_sel_decode #(.NUM_GEN(NUM_GEN), .IDX_W(IDX_W)) u_dec (
      .sel   (sel_in[k]),
      .ok    (s_ok[k]),
      .fb    (s_fb[k]),
      .fb_ct (s_ct[k]),
      .bank  (s_bank[k]),
      .idx   (s_idx[k])
    );
  end

  opf_rule_check u_rules (
    .merge_mode (merge_mode),
    .op         (opc_e'(op_class)),
    .wr_en      (wr_en),
    .sel_ok     (s_ok),
    .sel_fb     (s_fb),
    .sel_bank   (s_bank),
    .illegal    (illegal)
  );

  assign wr_ok    = wr_en && !illegal;
  assign r_idx[0] = s_idx[0];
  assign r_idx[1] = s_idx[1];

  opf_storage #(.DW(DW), .NUM_GEN(NUM_GEN), .IDX_W(IDX_W), .NRD(2)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .merge_mode (merge_mode),
    .we         (wr_ok),
    .w_fb       (s_fb[2]),
    .w_ct       (s_ct[2]),
    .w_bank     (s_bank[2]),
    .w_idx      (s_idx[2]),
    .w_data     (wr_data),
    .r_ok       (s_ok[1:0]),
    .r_fb       (s_fb[1:0]),
    .r_ct       (s_ct[1:0]),
    .r_bank     (s_bank[1:0]),
    .r_idx      (r_idx),
    .r_data     (r_data)
  );

  assign rd1_data = r_data[0];
  assign rd2_data = r_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_flag <= 1'b0;
    else if (illegal) err_flag <= 1'b1;
  end
endmodule

// File: rtl/opnd_regfile_checker.sv
module opnd_regfile_checker #(
  parameter int DW    = 64,
  parameter int IDX_W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           merge_mode,
  input logic [1:0]     op_class,
  input logic [IDX_W:0] src1_sel,
  input logic [IDX_W:0] src2_sel,
  input logic [IDX_W:0] dst_sel,
  input logic           wr_en,
  input logic [DW-1:0]  wr_data,
  input logic [DW-1:0]  rd1_data,
  input logic           illegal,
  input logic           err_flag
);
  // R9
  illegal_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> err_flag);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  // R6
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src1_sel[IDX_W-1:0] > 4'd11) |-> illegal);
  // R3
  wrong_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!merge_mode && op_class == 2'd0 && src1_sel[IDX_W] &&
     src1_sel[IDX_W-1:0] < 4'd10) |-> illegal);
  // R7
  merged_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_mode && src1_sel[IDX_W-1:0] < 4'd12 && src2_sel[IDX_W-1:0] < 4'd12 &&
     dst_sel[IDX_W-1:0] < 4'd12) |-> !illegal);
  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !illegal && src1_sel == dst_sel) |-> rd1_data == wr_data);
endmodule

bind opnd_regfile opnd_regfile_checker #(.DW(DW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .merge_mode(merge_mode), .op_class(op_class),
  .src1_sel(src1_sel), .src2_sel(src2_sel), .dst_sel(dst_sel),
  .wr_en(wr_en), .wr_data(wr_data), .rd1_data(rd1_data),
  .illegal(illegal), .err_flag(err_flag)
);

// File: tb/opnd_regfile_bench.sv
`timescale 1ns/100ps
module opnd_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        merge_mode = 1'b0;
  logic [1:0]  op_class = 2'd3;
  logic [4:0]  src1_sel = '0, src2_sel = '0, dst_sel = '0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd1_data, rd2_data;
  logic        illegal, err_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  opnd_regfile u_opnd_regfile (
    .clk(clk), .rst_n(rst_n), .merge_mode(merge_mode), .op_class(op_class),
    .src1_sel(src1_sel), .src2_sel(src2_sel), .dst_sel(dst_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd1_data(rd1_data), .rd2_data(rd2_data),
    .illegal(illegal), .err_flag(err_flag)
  );

  // merge, op, s1, s2, dst, we, wdata16, exp_illegal, exp_rd1_16, exp_rd2_16
  localparam int NV = 16;
  localparam logic [67:0] VEC [NV] = '{
    {1'b0,2'd3,5'd3, 5'd0, 5'd3, 1'b1,16'h1111,1'b0,16'h1111,16'h0000}, // R8 R5
    {1'b0,2'd0,5'd3, 5'd19,5'd19,1'b1,16'h2222,1'b0,16'h1111,16'h2222}, // R2 R5 R8
    {1'b0,2'd0,5'd19,5'd19,5'd0, 1'b0,16'h0000,1'b1,16'h2222,16'h2222}, // R3
    {1'b0,2'd0,5'd3, 5'd3, 5'd5, 1'b1,16'h5555,1'b1,16'h1111,16'h1111}, // R3 R9
    {1'b0,2'd3,5'd5, 5'd0, 5'd0, 1'b0,16'h0000,1'b0,16'h0000,16'h0000}, // R9
    {1'b0,2'd1,5'd3, 5'd15,5'd10,1'b1,16'hCCCC,1'b0,16'h1111,16'h0000}, // R4 R10
    {1'b0,2'd0,5'd26,5'd11,5'd0, 1'b0,16'h0000,1'b0,16'hCCCC,16'h0000}, // R6
    {1'b0,2'd2,5'd3, 5'd0, 5'd0, 1'b0,16'h0000,1'b1,16'h1111,16'h0000}, // R4
    {1'b0,2'd2,5'd19,5'd12,5'd0, 1'b0,16'h0000,1'b0,16'h2222,16'h0000}, // R4 R10
    {1'b0,2'd1,5'd19,5'd0, 5'd0, 1'b0,16'h0000,1'b1,16'h2222,16'h0000}, // R4
    {1'b0,2'd3,5'd12,5'd0, 5'd0, 1'b0,16'h0000,1'b1,16'h0000,16'h0000}, // R6
    {1'b0,2'd3,5'd0, 5'd0, 5'd13,1'b1,16'h9999,1'b1,16'h0000,16'h0000}, // R6 R9
    {1'b1,2'd0,5'd19,5'd3, 5'd0, 1'b0,16'h0000,1'b0,16'h1111,16'h1111}, // R7
    {1'b1,2'd3,5'd7, 5'd0, 5'd23,1'b1,16'h7777,1'b0,16'h7777,16'h0000}, // R7 R8
    {1'b0,2'd0,5'd7, 5'd23,5'd0, 1'b0,16'h0000,1'b0,16'h7777,16'h7777}, // R7
    {1'b0,2'd3,5'd11,5'd0, 5'd27,1'b1,16'h3C3C,1'b0,16'h3C3C,16'h0000}  // R6 R8
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [1:0] op, input logic [4:0] s1,
                       input logic [4:0] s2, input logic [4:0] d, input logic we,
                       input logic [63:0] wd);
    @(negedge clk);
    merge_mode = m; op_class = op; src1_sel = s1; src2_sel = s2;
    dst_sel = d; wr_en = we; wr_data = wd;
    #1;
  endtask

  function automatic logic [63:0] rep(input logic [15:0] w);
    return {4{w}};
  endfunction

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic exp_err;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    drive(1'b0, 2'd0, 5'd4, 5'd20, 5'd0, 1'b0, '0);
    chk("R1 rd1", rd1_data, '0);
    chk("R1 rd2", rd2_data, '0);
    chk("R1 err", {63'd0, err_flag}, 64'd0);
    drive(1'b0, 2'd0, 5'd10, 5'd11, 5'd0, 1'b0, '0);
    chk("R1 fb rd1", rd1_data, '0);
    chk("R1 fb rd2", rd2_data, '0);

    exp_err = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [67:0] v;
      v = VEC[i];
      drive(v[67], v[66:65], v[64:60], v[59:55], v[54:50], v[49],
            rep(v[48:33]));
      chk($sformatf("vec%0d illegal R3/R4/R6/R10", i), {63'd0, illegal}, {63'd0, v[32]});
      chk($sformatf("vec%0d rd1 R2/R7/R8/R9", i), rd1_data, rep(v[31:16]));
      chk($sformatf("vec%0d rd2 R2/R7", i), rd2_data, rep(v[15:0]));
      chk($sformatf("vec%0d err R9", i), {63'd0, err_flag}, {63'd0, exp_err});
      if (v[32]) exp_err = 1'b1;
    end

    // R9 sticky after legal traffic
    drive(1'b0, 2'd3, 5'd0, 5'd0, 5'd0, 1'b0, '0);
    drive(1'b0, 2'd3, 5'd0, 5'd0, 5'd0, 1'b0, '0);
    chk("R9 sticky", {63'd0, err_flag}, 64'd1);

    // R1 reset mid-run clears storage and flag
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    drive(1'b0, 2'd0, 5'd3, 5'd23, 5'd0, 1'b0, '0);
    chk("R1 after reset A3", rd1_data, '0);
    chk("R1 after reset B7", rd2_data, '0);
    chk("R1 after reset err", {63'd0, err_flag}, 64'd0);

    // R2 write committed on the edge, visible without bypass
    drive(1'b0, 2'd3, 5'd0, 5'd0, 5'd24, 1'b1, 64'h0123_4567_89AB_CDEF);
    drive(1'b0, 2'd0, 5'd8, 5'd24, 5'd0, 1'b0, '0);
    chk("R2 B8 stored", rd2_data, 64'h0123_4567_89AB_CDEF);
    chk("R2 A8 untouched", rd1_data, '0);
    chk("R9 legal keeps err low", {63'd0, err_flag}, 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule